// File: doc/BRIEF.md
# Address-Event Routing Fabric

This block moves address events among three event ports: a serial link, a parallel link and a host path. Each port has an incoming and an outgoing stream, and both use valid/ready handshakes. When an event is taken in, its address is shifted by a programmable per-source offset. A per-source filter then picks the set of destinations that receive a copy. A round-robin dispatcher moves each staged event into one small queue per destination, and each queue drives its output stream.

Flow control is lossless. When a destination cannot accept, its queue fills, the staged event waits, and the source's ready signal drops. Events are never dropped. A multi-destination event enters all of its target queues in one cycle, or enters none of them. Configuration arrives through a single write port. It is applied to an event at the edge where the event is taken in, so it can never change an event while that event is in flight.

Port index used throughout: 0 = serial link, 1 = parallel link, 2 = host path.

Top module: `ae_route_fabric`

## Requirements
- R1: After reset, every out_valid bit is 0 and every in_ready bit is 1.
- R2: The address an event carries out equals its input address plus the source's offset, modulo 2^AW.
- R3: Each source has a window [lo, hi], inclusive, compared against the offset address. An event inside the window uses the source's in-window mask (cfg_sel 3). Any other event uses its out-of-window mask (cfg_sel 4). Mask bit i selects port i. Other cfg_sel codes: 0 offset, 1 lo, 2 hi.
- R4: An event is never delivered to the port it arrived on, even when that port's mask bit is set.
- R5: Reset values are offset 0, lo 0, hi all ones and both masks 3'b111. By default an event reaches both other ports with its address unchanged.
- R6: A multi-destination event enters all of its destination queues in the same cycle. While any one of those queues is full, none of them receives it.
- R7: A blocked destination holds out_valid and out_addr steady until out_ready. The backpressure reaches the source as in_ready = 0. No event is lost, and order is kept for each source and destination pair.
- R8: When two sources compete for one destination every cycle, the grants alternate between them.
- R9: A single source can hand over one event on every clock when its destinations are ready.
- R10: A configuration write takes effect for events taken in on later edges. An event taken in on the same edge as the write uses the old settings.
- R11: An event taken in at edge k shows out_valid after edge k+1, provided its destination queue was empty and free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 3 | Per-port incoming event valid |
| in_addr | input | 3*AW | Per-port incoming address, port p in bits [p*AW +: AW] |
| in_ready | output | 3 | Per-port incoming ready |
| out_valid | output | 3 | Per-port outgoing event valid |
| out_addr | output | 3*AW | Per-port outgoing address |
| out_ready | input | 3 | Per-port outgoing ready |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | 2 | Source port whose settings are written (3 is ignored) |
| cfg_sel | input | 3 | Setting selected: 0 offset, 1 lo, 2 hi, 3 in-window mask, 4 out-of-window mask |
| cfg_wdata | input | AW | Write data; masks use the low 3 bits |

## Verification
An input handshake at edge k loads the staging register. The dispatch into the queues happens at edge k+1, so out_valid is due in the half cycle after edge k+1. The bench checks that it is still low one half cycle earlier, and all sampling happens at falling edges. Backpressure takes longer to reach a source. A source's in_ready falls only after the destination queue and the staging register are both full, so the bench waits a fixed number of cycles before it checks that in_ready has dropped and that the partner queue holds only the earlier events. The configuration-timing test puts an input handshake on the same edge as a write, then compares the next two outputs against the old and new offsets.

// File: rtl/ae_fabric_pkg.sv
package ae_fabric_pkg;
   localparam int NPORT = 3;
   localparam int SW    = $clog2(NPORT);

   typedef enum logic [2:0] {
      CFG_OFFSET   = 3'd0,
      CFG_LO       = 3'd1,
      CFG_HI       = 3'd2,
      CFG_MASK_IN  = 3'd3,
      CFG_MASK_OUT = 3'd4
   } cfg_sel_e;
endpackage

// File: rtl/ae_cfg_regs.sv
module ae_cfg_regs
   import ae_fabric_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          cfg_we,
   input  logic [1:0]                    cfg_port,
   input  logic [2:0]                    cfg_sel,
   input  logic [AW-1:0]                 cfg_wdata,
   output logic [NPORT-1:0][AW-1:0]      offset,
   output logic [NPORT-1:0][AW-1:0]      win_lo,
   output logic [NPORT-1:0][AW-1:0]      win_hi,
   output logic [NPORT-1:0][NPORT-1:0]   mask_in,
   output logic [NPORT-1:0][NPORT-1:0]   mask_out
);
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic hit;
      assign hit = cfg_we && (cfg_port == 2'(p));
      always_ff @(posedge clk) begin
         if (rst) begin
            offset[p]   <= '0;
            win_lo[p]   <= '0;
            win_hi[p]   <= '1;
            mask_in[p]  <= '1;
            mask_out[p] <= '1;
         end else if (hit) begin
            case (cfg_sel)
               CFG_OFFSET:   offset[p]   <= cfg_wdata;
               CFG_LO:       win_lo[p]   <= cfg_wdata;
               CFG_HI:       win_hi[p]   <= cfg_wdata;
               CFG_MASK_IN:  mask_in[p]  <= cfg_wdata[NPORT-1:0];
               CFG_MASK_OUT: mask_out[p] <= cfg_wdata[NPORT-1:0];
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/ae_ingress.sv
module ae_ingress
   import ae_fabric_pkg::*;
#(
   parameter int AW      = 16,
   parameter int PORT_ID = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [AW-1:0]    in_addr,
   output logic             in_ready,
   input  logic [AW-1:0]    offset,
   input  logic [AW-1:0]    win_lo,
   input  logic [AW-1:0]    win_hi,
   input  logic [NPORT-1:0] mask_in,
   input  logic [NPORT-1:0] mask_out,
   input  logic             fire,
   output logic             stg_v,
   output logic [AW-1:0]    stg_addr,
   output logic [NPORT-1:0] stg_mask
);
   localparam logic [NPORT-1:0] SELF = NPORT'(1) << PORT_ID;

   logic [AW-1:0]    mapped;
   logic             in_win;
   logic [NPORT-1:0] dest;

   assign mapped   = in_addr + offset;
   assign in_win   = (mapped >= win_lo) && (mapped <= win_hi);
   assign dest     = (in_win ? mask_in : mask_out) & ~SELF;
   assign in_ready = !stg_v || fire;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg_v    <= 1'b0;
         stg_addr <= '0;
         stg_mask <= '0;
      end else if (in_valid && in_ready) begin
         stg_v    <= 1'b1;
         stg_addr <= mapped;
         stg_mask <= dest;
      end else if (fire) begin
         stg_v    <= 1'b0;
      end
   end
endmodule

// File: rtl/ae_dispatch.sv
module ae_dispatch
   import ae_fabric_pkg::*;
(
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NPORT-1:0]            stg_v,
   input  logic [NPORT-1:0][NPORT-1:0] stg_mask,
   input  logic [NPORT-1:0]            q_full,
   output logic [NPORT-1:0]            fire,
   output logic [NPORT-1:0]            push,
   output logic [NPORT-1:0][SW-1:0]    push_src
);
   logic [SW-1:0]    ptr;
   logic [SW-1:0]    first;
   logic             found;
   logic [NPORT-1:0] claimed;

   always_comb begin
      claimed = '0;
      fire    = '0;
      first   = ptr;
      found   = 1'b0;
      for (int k = 0; k < NPORT; k++) begin
         int s;
         s = int'(ptr) + k;
         if (s >= NPORT) s = s - NPORT;
         if (stg_v[s] && ((stg_mask[s] & (claimed | q_full)) == '0)) begin
            fire[s] = 1'b1;
            claimed = claimed | stg_mask[s];
            if (!found) first = SW'(s);
            found = 1'b1;
         end
      end
   end

   always_comb begin
      push     = '0;
      push_src = '0;
      for (int d = 0; d < NPORT; d++) begin
         for (int s = 0; s < NPORT; s++) begin
            if (fire[s] && stg_mask[s][d]) begin
               push[d]     = 1'b1;
               push_src[d] = SW'(s);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)        ptr <= '0;
      else if (found) ptr <= (int'(first) == NPORT-1) ? '0 : first + 1'b1;
   end
endmodule

// File: rtl/ae_evt_fifo.sv
module ae_evt_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = (DEPTH == (1 << PW));

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [PW:0]   count;
   logic          do_push, do_pop;

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
   end

   assign full    = (count == (PW+1)'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ae_route_fabric.sv
module ae_route_fabric
   import ae_fabric_pkg::*;
#(
   parameter int AW         = 16,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        in_valid,
   input  logic [3*AW-1:0]   in_addr,
   output logic [2:0]        in_ready,
   output logic [2:0]        out_valid,
   output logic [3*AW-1:0]   out_addr,
   input  logic [2:0]        out_ready,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_port,
   input  logic [2:0]        cfg_sel,
   input  logic [AW-1:0]     cfg_wdata
);
   if (AW < NPORT) begin : g_bad_aw
      $error("ae_route_fabric: AW must hold a destination mask");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("ae_route_fabric: FIFO_DEPTH below 2 cannot sustain one event per clock");
   end

   logic [NPORT-1:0][AW-1:0]    offset, win_lo, win_hi;
   logic [NPORT-1:0][NPORT-1:0] mask_in, mask_out;
   logic [NPORT-1:0]            stg_v, src_fire, q_push, q_full, q_empty;
   logic [NPORT-1:0][AW-1:0]    stg_addr;
   logic [NPORT-1:0][NPORT-1:0] stg_mask;
   logic [NPORT-1:0][SW-1:0]    push_src;

   ae_cfg_regs #(.AW(AW)) u_cfg (
      .clk, .rst, .cfg_we, .cfg_port, .cfg_sel, .cfg_wdata,
      .offset, .win_lo, .win_hi, .mask_in, .mask_out
   );

   for (genvar s = 0; s < NPORT; s++) begin : g_src
      ae_ingress #(.AW(AW), .PORT_ID(s)) u_ing (
         .clk, .rst,
         .in_valid (in_valid[s]),
         .in_addr  (in_addr[s*AW +: AW]),
         .in_ready (in_ready[s]),
         .offset   (offset[s]),
         .win_lo   (win_lo[s]),
         .win_hi   (win_hi[s]),
         .mask_in  (mask_in[s]),
         .mask_out (mask_out[s]),
         .fire     (src_fire[s]),
         .stg_v    (stg_v[s]),
         .stg_addr (stg_addr[s]),
         .stg_mask (stg_mask[s])
      );
   end

   ae_dispatch u_disp (
      .clk, .rst, .stg_v, .stg_mask, .q_full,
      .fire (src_fire), .push (q_push), .push_src
   );

   for (genvar d = 0; d < NPORT; d++) begin : g_dst
      ae_evt_fifo #(.W(AW), .DEPTH(FIFO_DEPTH)) u_q (
         .clk, .rst,
         .push  (q_push[d]),
         .din   (stg_addr[push_src[d]]),
         .full  (q_full[d]),
         .pop   (out_ready[d]),
         .dout  (out_addr[d*AW +: AW]),
         .empty (q_empty[d])
      );
      assign out_valid[d] = !q_empty[d];
   end
endmodule

// File: rtl/ae_route_fabric_chk.sv
module ae_route_fabric_chk #(
   parameter int AW = 16
) (
   input logic            clk,
   input logic            rst,
   input logic [2:0]      out_valid,
   input logic [2:0]      out_ready,
   input logic [3*AW-1:0] out_addr,
   input logic [2:0]      stg_v,
   input logic [2:0]      src_fire,
   input logic [8:0]      stg_mask,
   input logic [3*AW-1:0] stg_addr,
   input logic [2:0]      q_push,
   input logic [2:0]      q_full
);
   for (genvar d = 0; d < 3; d++) begin : g_d
      AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
         out_valid[d] && !out_ready[d] |=> out_valid[d] && $stable(out_addr[d*AW +: AW])); // R7
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
         q_push[d] |-> !q_full[d]); // R7
      AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
         $countones({src_fire[0] && stg_mask[0*3+d],
                     src_fire[1] && stg_mask[1*3+d],
                     src_fire[2] && stg_mask[2*3+d]}) <= 1); // R8
   end
   for (genvar s = 0; s < 3; s++) begin : g_s
      AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
         stg_v[s] && !src_fire[s] |=> stg_v[s] && $stable(stg_addr[s*AW +: AW])
                                      && $stable(stg_mask[s*3 +: 3])); // R6
      AST_NO_SELF: assert property (@(posedge clk) disable iff (rst)
         stg_v[s] |-> !stg_mask[s*3+s]); // R4
   end
endmodule

bind ae_route_fabric ae_route_fabric_chk #(.AW(AW)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_addr  (out_addr),
   .stg_v     (stg_v),
   .src_fire  (src_fire),
   .stg_mask  (stg_mask),
   .stg_addr  (stg_addr),
   .q_push    (q_push),
   .q_full    (q_full)
);

// File: tb/test_ae_route_fabric.sv
`timescale 1ns/1ps
module test_ae_route_fabric;
   localparam int AW = 16;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [2:0]      iv = '0;
   logic [AW-1:0]   ia [3];
   logic [3*AW-1:0] in_addr;
   logic [2:0]      in_ready;
   logic [2:0]      out_valid;
   logic [3*AW-1:0] out_addr;
   logic [2:0]      ordy = 3'b111;
   logic            cfg_we = 1'b0;
   logic [1:0]      cfg_port = '0;
   logic [2:0]      cfg_sel = '0;
   logic [AW-1:0]   cfg_wdata = '0;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   logic [AW-1:0] q0[$];
   logic [AW-1:0] q1[$];
   logic [AW-1:0] q2[$];

   assign in_addr = {ia[2], ia[1], ia[0]};

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ae_route_fabric #(.AW(AW), .FIFO_DEPTH(4)) i_ae_route_fabric (
      .clk, .rst, .in_valid(iv), .in_addr, .in_ready,
      .out_valid, .out_addr, .out_ready(ordy),
      .cfg_we, .cfg_port, .cfg_sel, .cfg_wdata
   );

   always @(negedge clk) begin
      #3;
      if (!rst) begin
         if (out_valid[0] && ordy[0]) q0.push_back(out_addr[0 +: AW]);
         if (out_valid[1] && ordy[1]) q1.push_back(out_addr[AW +: AW]);
         if (out_valid[2] && ordy[2]) q2.push_back(out_addr[2*AW +: AW]);
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic send(input int p, input logic [AW-1:0] a);
      bit got;
      iv[p] = 1'b1;
      ia[p] = a;
      do begin
         #1;
         got = in_ready[p];
         @(posedge clk);
         if (!got) @(negedge clk);
      end while (!got);
      @(negedge clk);
      iv[p] = 1'b0;
   endtask

   task automatic cfg_wr(input int p, input logic [2:0] sel, input logic [AW-1:0] d);
      cfg_we = 1'b1; cfg_port = 2'(p); cfg_sel = sel; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drain();
      repeat (12) @(negedge clk);
   endtask

   task automatic clear_q();
      q0.delete(); q1.delete(); q2.delete();
   endtask

   task automatic t_reset();
      #1;
      chk(out_valid == 3'b000, "R1 out_valid after reset", 32'(out_valid), 0);
      chk(in_ready == 3'b111, "R1 in_ready after reset", 32'(in_ready), 7);
   endtask

   task automatic t_default();
      clear_q();
      send(1, 16'h1234);
      #1;
      chk(out_valid[0] == 1'b0, "R11 not yet valid at half cycle", 32'(out_valid[0]), 0);
      @(negedge clk); #1;
      chk(out_valid[0] && out_valid[2], "R11 valid after next edge", 32'(out_valid), 5);
      drain();
      chk(q0.size() == 1 && q0[0] == 16'h1234, "R5 port0 copy", (q0.size() > 0) ? 32'(q0[0]) : 32'hdead, 32'h1234);
      chk(q2.size() == 1 && q2[0] == 16'h1234, "R5 port2 copy", (q2.size() > 0) ? 32'(q2[0]) : 32'hdead, 32'h1234);
      chk(q1.size() == 0, "R4 no return to source", 32'(q1.size()), 0);
   endtask

   task automatic t_offset();
      clear_q();
      cfg_wr(0, 3'd0, 16'hFFF0);
      send(0, 16'h0020);
      send(0, 16'h1000);
      drain();
      chk(q1.size() == 2 && q1[0] == 16'h0010, "R2 offset wraps", (q1.size() > 0) ? 32'(q1[0]) : 32'hdead, 32'h0010);
      chk(q1.size() == 2 && q1[1] == 16'h0FF0, "R2 offset add", (q1.size() > 1) ? 32'(q1[1]) : 32'hdead, 32'h0FF0);
      chk(q2.size() == 2 && q2[0] == 16'h0010, "R2 offset on second dest", (q2.size() > 0) ? 32'(q2[0]) : 32'hdead, 32'h0010);
      cfg_wr(0, 3'd0, 16'h0000);
   endtask

   task automatic t_filter();
      clear_q();
      cfg_wr(1, 3'd1, 16'h0010);
      cfg_wr(1, 3'd2, 16'h001F);
      cfg_wr(1, 3'd3, 16'h0003);
      cfg_wr(1, 3'd4, 16'h0004);
      send(1, 16'h000F);
      send(1, 16'h0010);
      send(1, 16'h001F);
      send(1, 16'h0020);
      drain();
      chk(q0.size() == 2, "R3 in-window count", 32'(q0.size()), 2);
      chk(q0.size() == 2 && q0[0] == 16'h0010 && q0[1] == 16'h001F, "R3 window edges inclusive",
          (q0.size() > 0) ? 32'(q0[0]) : 32'hdead, 32'h0010);
      chk(q2.size() == 2 && q2[0] == 16'h000F && q2[1] == 16'h0020, "R3 outside window",
          (q2.size() > 0) ? 32'(q2[0]) : 32'hdead, 32'h000F);
      chk(q1.size() == 0, "R4 self bit ignored", 32'(q1.size()), 0);
      cfg_wr(1, 3'd1, 16'h0000);
      cfg_wr(1, 3'd2, 16'hFFFF);
      cfg_wr(1, 3'd3, 16'h0007);
      cfg_wr(1, 3'd4, 16'h0007);
   endtask

   task automatic t_cfg_timing();
      clear_q();
      iv[2] = 1'b1; ia[2] = 16'h0100;
      cfg_we = 1'b1; cfg_port = 2'd2; cfg_sel = 3'd0; cfg_wdata = 16'h0005;
      #1;
      chk(in_ready[2] == 1'b1, "R10 ready with write", 32'(in_ready[2]), 1);
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0; ia[2] = 16'h0200;
      @(posedge clk); @(negedge clk);
      iv[2] = 1'b0;
      drain();
      chk(q0.size() == 2 && q0[0] == 16'h0100, "R10 same-edge event keeps old offset",
          (q0.size() > 0) ? 32'(q0[0]) : 32'hdead, 32'h0100);
      chk(q0.size() == 2 && q0[1] == 16'h0205, "R10 later event uses new offset",
          (q0.size() > 1) ? 32'(q0[1]) : 32'hdead, 32'h0205);
      cfg_wr(2, 3'd0, 16'h0000);
   endtask

   task automatic t_stall();
      clear_q();
      ordy[1] = 1'b0;
      for (int i = 0; i < 5; i++) send(0, 16'(16'h0A00 + i));
      repeat (4) @(negedge clk);
      #1;
      chk(q2.size() == 4, "R6 blocked event not sent to free dest", 32'(q2.size()), 4);
      chk(in_ready[0] == 1'b0, "R7 backpressure reaches source", 32'(in_ready[0]), 0);
      chk(out_valid[1] && out_addr[AW +: AW] == 16'h0A00, "R7 blocked output held",
          32'(out_addr[AW +: AW]), 32'h0A00);
      ordy[1] = 1'b1;
      drain();
      chk(q1.size() == 5, "R7 nothing lost port1", 32'(q1.size()), 5);
      chk(q2.size() == 5, "R6 all copies port2", 32'(q2.size()), 5);
      for (int i = 0; i < 5 && i < q1.size(); i++)
         chk(q1[i] == 16'(16'h0A00 + i), "R7 order kept", 32'(q1[i]), 32'(16'h0A00 + i));
   endtask

   task automatic t_rr();
      clear_q();
      cfg_wr(0, 3'd3, 16'h0002); cfg_wr(0, 3'd4, 16'h0002);
      cfg_wr(2, 3'd3, 16'h0002); cfg_wr(2, 3'd4, 16'h0002);
      fork
         for (int i = 0; i < 4; i++) send(0, 16'(16'h0100 + i));
         for (int i = 0; i < 4; i++) send(2, 16'(16'h0300 + i));
      join
      drain();
      chk(q1.size() == 8, "R8 all contenders delivered", 32'(q1.size()), 8);
      for (int i = 0; i + 1 < q1.size(); i++)
         chk(q1[i][15:8] != q1[i+1][15:8], "R8 grants alternate", 32'(q1[i+1]), 32'(q1[i]));
      cfg_wr(0, 3'd3, 16'h0007); cfg_wr(0, 3'd4, 16'h0007);
      cfg_wr(2, 3'd3, 16'h0007); cfg_wr(2, 3'd4, 16'h0007);
   endtask

   task automatic t_rate();
      int start;
      clear_q();
      start = cyc;
      for (int i = 0; i < 8; i++) send(1, 16'(16'h0C00 + i));
      chk(cyc - start == 8, "R9 one event per clock", 32'(cyc - start), 8);
      drain();
      chk(q0.size() == 8 && q0[7] == 16'h0C07, "R9 stream at port0",
          32'(q0.size()), 8);
      chk(q2.size() == 8 && q2[0] == 16'h0C00, "R9 stream at port2",
          32'(q2.size()), 8);
   endtask

   initial begin
      ia[0] = '0; ia[1] = '0; ia[2] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      @(negedge clk);
      t_default();
      t_offset();
      t_filter();
      t_cfg_timing();
      t_stall();
      t_rr();
      t_rate();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule